// File: doc/BRIEF.md
# Line loss-of-signal detector

This block watches the recovered receive bit stream of one line port, one bit per recovered clock qualified by a valid strobe, and drives a registered loss-of-signal flag. A long unbroken run of zero bits declares loss. Loss is released only after a full window of bits passes in which no excessive-zero run is seen. What counts as an excessive-zero run depends on a line-mode input: three zeros in the three-zero mode (DS3/STS-1 lines) and four zeros in the four-zero mode (E3 lines). One instance serves one port.

The controller is a two-state machine. `ST_LOST` (the reset state, flag high) leaves through the transition `window_clean` when the window timer completes a clean window. `ST_LOCKED` (flag low) leaves through the transition `run_full` when the zero-run counter reaches its full length. A zero-run counter and a window timer feed the machine. The counter restarts on every one bit and saturates at its full length. The timer runs only in `ST_LOST` and restarts on every bit that belongs to an excessive-zero run.

Top module: `los_detector`

## Requirements
- R1: Synchronous active-high reset clears the zero-run count and the window count and sets `los` to 1. After reset, `los` stays 1 until a full clean window of 192 valid bits has been received.
- R2: In `ST_LOCKED`, `los` goes to 1 on the clock after the 192nd consecutive valid zero bit. A run of 191 zeros followed by a one leaves `los` at 0.
- R3: A valid one bit sets the zero-run count back to zero.
- R4: In `ST_LOST`, `los` goes to 0 on the clock after the 192nd consecutive valid bit that does not belong to an excessive-zero run. An excessive bit anywhere in the window restarts the count of 192 from zero.
- R5: With `line_mode` = 0 (three-zero mode), a zero that brings the current run to 3 or more is excessive. A run of 2 zeros is not excessive.
- R6: With `line_mode` = 1 (four-zero mode), a zero that brings the current run to 4 or more is excessive. A run of 3 zeros is not excessive.
- R7: A cycle with `rx_valid` = 0 changes no count and does not change `los`, whatever `rx_bit` is.
- R8: A change of `line_mode` applies from the next valid bit on. It does not clear the zero-run count, so a run already in progress is measured against the new threshold.
- R9: The zero-run count saturates at 192. An arbitrarily long zero run keeps `los` at 1, and the first one bit after such a run starts a fresh 192-bit window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Qualifies `rx_bit` on this clock |
| rx_bit | input | 1 | Received data bit |
| line_mode | input | 1 | 0 = three-zero rule, 1 = four-zero rule |
| los | output | 1 | Registered loss-of-signal flag |

## Verification
A zero-run count that is too high or too low shows up as `los` rising one bit early or late, or not rising at all after 192 zeros. A window count that fails to restart shows up as `los` falling while short zero runs are still arriving. A wrong threshold shows up as `los` falling too soon, or not at all, under a run pattern just below or just above the mode's limit. Each of these faults appears at `los` within one window of 192 bits of the stimulus that exposes it. The scoreboard compares `los` after every bit, so the first wrong cycle is reported.

// File: rtl/los_pkg.sv
package los_pkg;

    typedef enum logic {
        ST_LOST   = 1'b0,
        ST_LOCKED = 1'b1
    } los_state_e;

    typedef enum logic {
        MODE_3ZERO = 1'b0,
        MODE_4ZERO = 1'b1
    } line_mode_e;

endpackage

// File: rtl/zero_run_counter.sv
module zero_run_counter
    import los_pkg::*;
#(
    parameter int RUN_LEN = 192,
    parameter int THR_3Z  = 3,
    parameter int THR_4Z  = 4,
    localparam int CW     = $clog2(RUN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_vld,
    input  logic          bit_val,
    input  line_mode_e    mode,
    output logic [CW-1:0] run_cnt,
    output logic          run_full,
    output logic          excess_bit
);

    localparam logic [CW-1:0] RUN_MAX  = CW'(RUN_LEN);
    localparam logic [CW-1:0] RUN_LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] thr;
    logic [CW-1:0] run_nxt;
    logic          zero_in;

    always_comb begin
        unique case (mode)
            MODE_3ZERO: thr = CW'(THR_3Z);
            MODE_4ZERO: thr = CW'(THR_4Z);
            default:    thr = CW'(THR_3Z);
        endcase
    end

    assign zero_in = bit_vld && !bit_val;

    always_comb begin
        if (bit_val)
            run_nxt = '0;
        else if (run_cnt == RUN_MAX)
            run_nxt = run_cnt;
        else
            run_nxt = run_cnt + 1'b1;
    end

    assign excess_bit = zero_in && (run_nxt >= thr);
    assign run_full   = zero_in && (run_cnt == RUN_LAST);

    always_ff @(posedge clk) begin
        if (rst)
            run_cnt <= '0;
        else if (bit_vld)
            run_cnt <= run_nxt;
    end

    assert_run_saturates_R9: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= RUN_MAX);

    assert_one_clears_run_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bit_vld) && $past(bit_val)) |-> run_cnt == '0);

    assert_idle_holds_run_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bit_vld)) |-> $stable(run_cnt));

endmodule

// File: rtl/window_timer.sv
module window_timer #(
    parameter int WIN_LEN = 192,
    localparam int WW     = $clog2(WIN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          armed,
    input  logic          tick,
    input  logic          restart,
    output logic [WW-1:0] win_cnt,
    output logic          expire
);

    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);

    assign expire = armed && tick && !restart && (win_cnt == WIN_LAST);

    always_ff @(posedge clk) begin
        if (rst || !armed)
            win_cnt <= '0;
        else if (tick) begin
            if (restart || expire)
                win_cnt <= '0;
            else
                win_cnt <= win_cnt + 1'b1;
        end
    end

    assert_window_bound_R4: assert property (@(posedge clk) disable iff (rst)
        win_cnt <= WIN_LAST);

    assert_idle_window_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(armed)) |-> win_cnt == '0);

endmodule

// File: rtl/los_detector.sv
module los_detector
    import los_pkg::*;
#(
    parameter int RUN_LEN = 192,
    parameter int WIN_LEN = 192,
    parameter int THR_3Z  = 3,
    parameter int THR_4Z  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_valid,
    input  logic rx_bit,
    input  logic line_mode,
    output logic los
);

    localparam int CW = $clog2(RUN_LEN + 1);
    localparam int WW = $clog2(WIN_LEN + 1);

    los_state_e    state_q, state_d;
    line_mode_e    mode;
    logic [CW-1:0] run_cnt;
    logic          run_full;
    logic          excess_bit;
    logic [WW-1:0] win_cnt;
    logic          win_done;

    assign mode = line_mode_e'(line_mode);

    zero_run_counter #(
        .RUN_LEN (RUN_LEN),
        .THR_3Z  (THR_3Z),
        .THR_4Z  (THR_4Z)
    ) u_run (
        .clk        (clk),
        .rst        (rst),
        .bit_vld    (rx_valid),
        .bit_val    (rx_bit),
        .mode       (mode),
        .run_cnt    (run_cnt),
        .run_full   (run_full),
        .excess_bit (excess_bit)
    );

    window_timer #(
        .WIN_LEN (WIN_LEN)
    ) u_win (
        .clk     (clk),
        .rst     (rst),
        .armed   (state_q == ST_LOST),
        .tick    (rx_valid),
        .restart (excess_bit),
        .win_cnt (win_cnt),
        .expire  (win_done)
    );

    // Transitions: run_full (LOCKED -> LOST), window_clean (LOST -> LOCKED)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (run_full) state_d = ST_LOST;
            ST_LOST:   if (win_done) state_d = ST_LOCKED;
            default:   state_d = ST_LOST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_LOST;
        else
            state_q <= state_d;
    end

    always_comb begin
        los = (state_q == ST_LOST);
    end

    assert_rise_after_full_run_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(los) |-> ($past(run_cnt) == CW'(RUN_LEN - 1) && $past(rx_valid) && !$past(rx_bit)));

    assert_fall_after_clean_window_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(los) |-> ($past(win_cnt) == WW'(WIN_LEN - 1) && $past(rx_valid) && !$past(excess_bit)));

    assert_excess_restarts_window_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOST && excess_bit) |=> (los && win_cnt == '0));

    assert_idle_keeps_flag_R7: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> $stable(los));

endmodule

// File: tb/sim_los_detector.sv
`timescale 1ns/1ps
module sim_los_detector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 1'b0;
    logic rx_bit = 1'b0;
    logic line_mode = 1'b0;
    logic los;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic  exp_q[$];
    string tag_q[$];
    string cur_tag = "R1";

    // reference state, built from the requirements
    logic  mode_r = 1'b0;
    int    rl = 0;
    int    win = 0;
    logic  m_los = 1'b1;

    always #5 clk = ~clk;

    los_detector u0 (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit),
        .line_mode (line_mode),
        .los       (los)
    );

    task automatic send(input logic b, input logic v);
        int  thr;
        bit  exc;
        @(negedge clk);
        rx_bit = b;
        rx_valid = v;
        line_mode = mode_r;
        if (v) begin
            thr = mode_r ? 4 : 3;
            if (b) rl = 0;
            else if (rl < 192) rl++;
            exc = !b && (rl >= thr);
            if (m_los) begin
                if (exc) win = 0;
                else begin
                    win++;
                    if (win == 192) begin m_los = 1'b0; win = 0; end
                end
            end else if (!b && rl == 192) begin
                m_los = 1'b1;
                win = 0;
            end
        end
        exp_q.push_back(m_los);
        tag_q.push_back(cur_tag);
    endtask

    task automatic send_n(input logic b, input int n);
        for (int i = 0; i < n; i++) send(b, 1'b1);
    endtask

    // repeat a pattern of (z zeros then one 1) for n bits total
    task automatic runs(input int z, input int n);
        for (int i = 0; i < n; i++) send((i % (z + 1)) == z, 1'b1);
    endtask

    // monitor: compares the flag after each driven bit
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (los !== e) begin
                failures++;
                $display("FAIL %s: los=%b expected=%b at %0t", t, los, e, $time);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (los !== 1'b1) begin
            failures++;
            $display("FAIL R1: los=%b expected=1 after reset", los);
        end
        // R1: reset flag holds until a full clean window
        cur_tag = "R1"; send_n(1'b1, 192);
        // R2: 191 zeros then a one do not assert; 192 do
        cur_tag = "R2"; send_n(1'b0, 191); send(1'b1, 1'b1);
        // R3: the one restarted the run, so 191 more zeros stay locked
        cur_tag = "R3"; send_n(1'b0, 191); send(1'b1, 1'b1);
        cur_tag = "R2"; send_n(1'b0, 192);
        // R5: runs of 2 are clean in three-zero mode
        cur_tag = "R5"; runs(2, 200);
        cur_tag = "R2"; send_n(1'b0, 192);
        // R5 and R4: a run of 3 late in the window restarts it
        cur_tag = "R5"; send_n(1'b1, 150); send_n(1'b0, 3);
        cur_tag = "R4"; send_n(1'b1, 191); send(1'b1, 1'b1);
        // R6: runs of 3 are clean in four-zero mode; runs of 4 are not
        mode_r = 1'b1;
        cur_tag = "R6"; send_n(1'b0, 192); runs(3, 200);
        send_n(1'b0, 192); runs(4, 300); send_n(1'b1, 192);
        // R7: invalid zeros count for nothing
        cur_tag = "R7"; send_n(1'b0, 190);
        for (int i = 0; i < 40; i++) send(1'b0, 1'b0);
        send(1'b0, 1'b1); send(1'b1, 1'b0); send(1'b0, 1'b1);
        // R7: invalid cycles inside the window do not advance it
        send_n(1'b1, 100);
        for (int i = 0; i < 30; i++) send(1'b1, 1'b0);
        send_n(1'b1, 92);
        // R8: mode switch mid-run keeps the count
        cur_tag = "R8"; send_n(1'b1, 150); send_n(1'b0, 3);
        mode_r = 1'b0; send(1'b0, 1'b1); send_n(1'b1, 191); send(1'b1, 1'b1);
        send_n(1'b0, 192);
        mode_r = 1'b1; send_n(1'b1, 100); send_n(1'b0, 2);
        mode_r = 1'b0; send(1'b0, 1'b1); send_n(1'b1, 192);
        // R9: long zero run saturates, fresh window after the first one
        cur_tag = "R9"; send_n(1'b0, 400); send_n(1'b1, 191); send(1'b1, 1'b1);
        send_n(1'b1, 4);
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule